// File: doc/BRIEF.md
# Software-Clocked Serial EEPROM Responder

This block stands in for a small read-only serial EEPROM that host software drives one bit at a time. The host owns one 32-bit control register. It moves a clock bit and a data-in bit by writing the whole register over and over. The block detects each low-to-high change of the clock bit by comparing the written value with the value already held. On each such change it advances a command sequencer by one step.

A command starts with an 8-bit opcode sent most significant bit first. The read opcode is followed by an 8-bit word address, and then by 16 steps that each present one bit of the addressed 16-bit word on the data-out bit, least significant bit first. The status opcode is followed by 8 steps that present 0. The storage is a parameterised array of 16-bit words, 64 by default. Word 0 holds 0xBABA and every other word holds 0. A sticky error flag records misuse. Each error also returns the sequencer to the start of a command.

The sequencer has four states: `ST_OPCODE` (collecting opcode bits), `ST_ADDR` (collecting address bits), `ST_DATA` (sending word bits) and `ST_STATUS` (sending status bits). The transitions are:
- `ST_OPCODE`→`ST_ADDR` on the 8th opcode bit when it completes the read opcode.
- `ST_OPCODE`→`ST_STATUS` on the 8th opcode bit when it completes the status opcode.
- `ST_OPCODE`→`ST_OPCODE` with an error when any other opcode completes.
- `ST_ADDR`→`ST_DATA` on the 8th address bit when the address lies inside the storage.
- `ST_ADDR`→`ST_OPCODE` with an error when the address lies outside the storage.
- `ST_DATA`→`ST_OPCODE` after the 16th data bit.
- `ST_STATUS`→`ST_OPCODE` after the 8th status bit.

Every return to `ST_OPCODE` clears the opcode, the address and all three bit counters.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the control register reads 0x00000110, with bit 4 (lowest write-enable field bit) and bit 8 (type bit) at 1 and every other bit at 0. The error flag is 0.
- R2: A sequencer step happens only on an accepted write whose bit 0 (clock) is 1 while the held clock bit is 0. A write that keeps the clock at 1 or clears it moves neither the sequencer nor data-out.
- R3: On each step in `ST_OPCODE`, bit 2 (data-in) shifts into the opcode at the least significant end, so the first bit sent ends at bit 7. Opcode 0x03 selects a word read.
- R4: After a read opcode, 8 further steps shift data-in into an 8-bit address in the same way, most significant bit first.
- R5: In a read, the n-th data step (n = 0..15) drives bit n of the addressed word onto bit 3 (data-out), visible on the readback after that write. Word 0 is 0xBABA and every other word is 0.
- R6: Opcode 0x05 selects a status read: the next 8 steps each drive data-out to 0.
- R7: After the last data bit of a read or the last status bit, the next step begins a new opcode, so commands may follow one another without any other access.
- R8: Any completed opcode other than 0x03 or 0x05 sets the error flag and returns the sequencer to the opcode phase. The error flag stays set until reset.
- R9: A read address not below the storage depth sets the error flag and returns the sequencer to the opcode phase, with no data phase.
- R10: Every accepted write sets bit 7 (grant) equal to bit 6 (request) of the value written.
- R11: The readback returns the last accepted write value, with bit 3 replaced by the driven data-out and bit 7 by the grant.
- R12: A write with any byte enable low is ignored completely: no register bit, grant or sequencer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables; only 4'hF is accepted |
| wr_data | input | 32 | Value to write into the control register |
| rd_data | output | 32 | Current control register readback |
| err | output | 1 | Sticky protocol error flag |

## Verification
The hardest situations to reach are those where a write arrives that looks like a step but must not count: a repeated write with the clock held high and data-in flipped, or a partial write that raises the clock bit. These have to land in the middle of a read, where a wrongly counted step would show up at once in the returned word. The stimulus inserts such writes after every real step of a full word read, and then checks that the word still comes back intact. The error paths need a fresh reset each, because the flag is sticky. A sweep reads every storage address back to back to cover the data path fully.

// File: rtl/eebb_pkg.sv
package eebb_pkg;
    // Control register bit positions (host software decodes these)
    localparam int CB_CLK  = 0;
    localparam int CB_DIN  = 2;
    localparam int CB_DOUT = 3;
    localparam int CB_REQ  = 6;
    localparam int CB_GNT  = 7;

    // Reset value: write-enable field low bit (4) and type bit (8) set
    localparam logic [31:0] CTRL_RST = 32'h0000_0110;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_STATUS = 8'h05;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_ADDR   = 2'd1,
        ST_DATA   = 2'd2,
        ST_STATUS = 2'd3
    } seq_state_t;
endpackage

// File: rtl/eebb_ctrl_reg.sv
module eebb_ctrl_reg
    import eebb_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int BE_W  = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic             gnt_q,
    output logic             sclk_rise,
    output logic             din_bit
);
    logic accept;

    // Only complete-word writes are taken
    assign accept    = wr_en && (&wr_be);
    assign sclk_rise = accept && wr_data[CB_CLK] && !ctrl_q[CB_CLK];
    assign din_bit   = wr_data[CB_DIN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= REG_W'(CTRL_RST);
            gnt_q  <= 1'b0;
        end else if (accept) begin
            ctrl_q <= wr_data;
            gnt_q  <= wr_data[CB_REQ];
        end
    end
endmodule

// File: rtl/eebb_store.sv
module eebb_store #(
    parameter int              DEPTH = 64,
    parameter int              AW    = 8,
    parameter int              DW    = 16,
    parameter logic [DW-1:0]   WORD0 = DW'(16'hBABA)
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SLOTS = 1 << IDX_W;

    logic [DW-1:0] words [SLOTS];

    function automatic logic [DW-1:0] preload(input int idx);
        return (idx == 0) ? WORD0 : '0;
    endfunction

    for (genvar i = 0; i < SLOTS; i++) begin : g_word
        if (i < DEPTH) begin : g_used
            assign words[i] = preload(i);
        end else begin : g_pad
            assign words[i] = '0;
        end
    end

    always_comb begin
        if (int'(addr) < DEPTH)
            word = words[addr[IDX_W-1:0]];
        else
            word = '0;
    end
endmodule

// File: rtl/eebb_seq.sv
module eebb_seq
    import eebb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OP_W  = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int SW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          din,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_q,
    output logic          dout_q,
    output logic          err_q,
    output seq_state_t    state_q
);
    localparam int OCW   = $clog2(OP_W + 1);
    localparam int ACW   = $clog2(AW + 1);
    localparam int DCW   = $clog2(DW + 1);
    localparam int DIDXW = $clog2(DW);
    localparam logic [OCW-1:0] OC_LAST = OCW'(OP_W - 1);
    localparam logic [ACW-1:0] AC_LAST = ACW'(AW - 1);
    localparam logic [DCW-1:0] DC_LAST = DCW'(DW - 1);
    localparam logic [DCW-1:0] SC_LAST = DCW'(SW - 1);

    seq_state_t       state_n;
    logic [OP_W-1:0]  op_q, op_n, op_shift;
    logic [AW-1:0]    addr_n, addr_shift;
    logic [OCW-1:0]   oc_q, oc_n;
    logic [ACW-1:0]   ac_q, ac_n;
    logic [DCW-1:0]   dc_q, dc_n;
    logic             dout_n, err_n, bad;

    assign op_shift   = {op_q[OP_W-2:0], din};
    assign addr_shift = {addr_q[AW-2:0], din};

    // Next-state and sequencing logic
    always_comb begin
        state_n = state_q;
        op_n    = op_q;
        addr_n  = addr_q;
        oc_n    = oc_q;
        ac_n    = ac_q;
        dc_n    = dc_q;
        bad     = 1'b0;
        if (step) begin
            unique case (state_q)
                ST_OPCODE: begin
                    op_n = op_shift;
                    oc_n = oc_q + 1'b1;
                    if (oc_q == OC_LAST) begin
                        if (op_shift == OP_W'(OP_READ)) begin
                            state_n = ST_ADDR;
                        end else if (op_shift == OP_W'(OP_STATUS)) begin
                            state_n = ST_STATUS;
                        end else begin
                            bad     = 1'b1;
                            state_n = ST_OPCODE;
                            op_n    = '0;
                            oc_n    = '0;
                        end
                    end
                end
                ST_ADDR: begin
                    addr_n = addr_shift;
                    ac_n   = ac_q + 1'b1;
                    if (ac_q == AC_LAST) begin
                        if (int'(addr_shift) >= DEPTH) begin
                            bad     = 1'b1;
                            state_n = ST_OPCODE;
                            op_n    = '0;
                            addr_n  = '0;
                            oc_n    = '0;
                            ac_n    = '0;
                        end else begin
                            state_n = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    dc_n = dc_q + 1'b1;
                    if (dc_q == DC_LAST) begin
                        state_n = ST_OPCODE;
                        op_n    = '0;
                        addr_n  = '0;
                        oc_n    = '0;
                        ac_n    = '0;
                        dc_n    = '0;
                    end
                end
                ST_STATUS: begin
                    dc_n = dc_q + 1'b1;
                    if (dc_q == SC_LAST) begin
                        state_n = ST_OPCODE;
                        op_n    = '0;
                        addr_n  = '0;
                        oc_n    = '0;
                        ac_n    = '0;
                        dc_n    = '0;
                    end
                end
                default: begin
                    bad     = 1'b1;
                    state_n = ST_OPCODE;
                    op_n    = '0;
                    addr_n  = '0;
                    oc_n    = '0;
                    ac_n    = '0;
                    dc_n    = '0;
                end
            endcase
        end
    end

    // Output logic: data-out drive and error flag
    always_comb begin
        dout_n = dout_q;
        err_n  = err_q | bad;
        if (step) begin
            unique case (state_q)
                ST_DATA:   dout_n = rd_word[dc_q[DIDXW-1:0]];
                ST_STATUS: dout_n = 1'b0;
                default:   dout_n = dout_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            op_q    <= '0;
            addr_q  <= '0;
            oc_q    <= '0;
            ac_q    <= '0;
            dc_q    <= '0;
            dout_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            op_q    <= op_n;
            addr_q  <= addr_n;
            oc_q    <= oc_n;
            ac_q    <= ac_n;
            dc_q    <= dc_n;
            dout_q  <= dout_n;
            err_q   <= err_n;
        end
    end
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
    import eebb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        err
);
    logic [31:0]   ctrl_q;
    logic          gnt_q, sclk_rise, din_bit, dout_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rd_word;
    seq_state_t    seq_st;

    eebb_ctrl_reg #(.REG_W(32)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .gnt_q     (gnt_q),
        .sclk_rise (sclk_rise),
        .din_bit   (din_bit)
    );

    eebb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .addr (addr_q),
        .word (rd_word)
    );

    eebb_seq #(.DEPTH(DEPTH), .OP_W(8), .AW(AW), .DW(DW), .SW(8)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sclk_rise),
        .din     (din_bit),
        .rd_word (rd_word),
        .addr_q  (addr_q),
        .dout_q  (dout_q),
        .err_q   (err),
        .state_q (seq_st)
    );

    always_comb begin
        rd_data          = ctrl_q;
        rd_data[CB_DOUT] = dout_q;
        rd_data[CB_GNT]  = gnt_q;
    end
endmodule

// File: rtl/spi_eeprom_emu_chk.sv
module spi_eeprom_emu_chk
    import eebb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_be,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        err,
    input seq_state_t  seq_st
);
    logic full_wr, rising;
    assign full_wr = wr_en && (wr_be == 4'hF);
    assign rising  = full_wr && wr_data[CB_CLK] && !rd_data[CB_CLK];

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_partial_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !full_wr |=> $stable(rd_data));

    assert_gnt_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_wr |=> (rd_data[CB_GNT] == $past(wr_data[CB_REQ])));

    assert_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
        full_wr |=> (rd_data[31:8] == $past(wr_data[31:8])) &&
                    (rd_data[2:0] == $past(wr_data[2:0])));

    assert_no_step_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && !rising) |=> $stable(rd_data[CB_DOUT]));

    assert_status_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rising && seq_st == ST_STATUS) |=> !rd_data[CB_DOUT]);
endmodule

bind spi_eeprom_emu spi_eeprom_emu_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .err     (err),
    .seq_st  (seq_st)
);

// File: tb/spi_eeprom_emu_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_emu_tb_top;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_eeprom_emu #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .err(err)
    );

    function automatic logic [15:0] exp_word(input int a);
        return (a == 0) ? 16'hBABA : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] v, input logic [3:0] be = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One serial step; optional redundant and partial writes after it
    task automatic clock_bit(input logic d, output logic q, input bit noisy = 0);
        put({29'd0, d, 2'b00});
        put({29'd0, d, 2'b01});
        q = rd_data[3];
        if (noisy) begin
            put({29'd0, ~d, 2'b01});           // clock held high
            chk(rd_data[3] == q, "R2", {31'd0, rd_data[3]}, {31'd0, q});
            put({29'd0, ~d, 2'b00}, 4'h7);     // partial write, ignored
            chk(rd_data[0] == 1'b1, "R12", rd_data, {31'd0, 1'b1});
            put({29'd0, ~d, 2'b01}, 4'hE);     // partial write with clock
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit noisy = 0);
        logic q;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], q, noisy);
    endtask

    task automatic read_word(input logic [7:0] a, output logic [15:0] w, input bit noisy = 0);
        logic q;
        send_byte(8'h03, noisy);
        send_byte(a, noisy);
        for (int i = 0; i < 16; i++) begin
            clock_bit(1'b0, q, noisy);
            w[i] = q;
            chk(q == exp_word(a)[i], "R5", {31'd0, q}, {31'd0, exp_word(a)[i]});
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic q;
        logic [31:0] v, e;

        do_reset();
        // R1: reset state
        chk(rd_data == 32'h0000_0110, "R1", rd_data, 32'h0000_0110);
        chk(err == 1'b0, "R1", {31'd0, err}, 32'd0);

        // R3 R4 R5 R7: sweep every address back to back
        for (int a = 0; a < DEPTH; a++) begin
            read_word(8'(a), w);
            chk(w == exp_word(a), "R7", {16'd0, w}, {16'd0, exp_word(a)});
        end
        chk(err == 1'b0, "R4", {31'd0, err}, 32'd0);

        // R6: status read after word 0 left data-out at 1
        read_word(8'h00, w);
        chk(rd_data[3] == 1'b1, "R5", rd_data, 32'h8);
        send_byte(8'h05);
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, q);
            chk(q == 1'b0, "R6", {31'd0, q}, 32'd0);
        end
        // R7: read straight after status
        read_word(8'h00, w);
        chk(w == 16'hBABA, "R7", {16'd0, w}, 32'hBABA);
        send_byte(8'h05);
        for (int i = 0; i < 8; i++) clock_bit(1'b0, q);

        // R10 R11 with data-out at 0
        v = 32'hA5A5_5A74;
        put(v);
        e = (v & ~32'h88) | 32'h80;
        chk(rd_data == e, "R11", rd_data, e);
        chk(rd_data[7] == 1'b1, "R10", rd_data, e);
        v = 32'h3C3C_C38A;
        put(v);
        e = v & ~32'h88;
        chk(rd_data == e, "R11", rd_data, e);
        chk(rd_data[7] == 1'b0, "R10", rd_data, e);
        // R12: partial write leaves everything
        put(32'hFFFF_FFFF, 4'hB);
        chk(rd_data == e, "R12", rd_data, e);
        put(32'h0000_0000);

        // R2 R12: noisy read of word 0
        read_word(8'h00, w, 1);
        chk(w == 16'hBABA, "R2", {16'd0, w}, 32'hBABA);
        chk(err == 1'b0, "R12", {31'd0, err}, 32'd0);

        // R9: out-of-range addresses
        do_reset();
        send_byte(8'h03);
        send_byte(8'(DEPTH));
        chk(err == 1'b1, "R9", {31'd0, err}, 32'd1);
        read_word(8'h00, w);
        chk(w == 16'hBABA, "R9", {16'd0, w}, 32'hBABA);
        do_reset();
        send_byte(8'h03);
        send_byte(8'hFF);
        chk(err == 1'b1, "R9", {31'd0, err}, 32'd1);

        // R8: unknown opcode, then recovery
        do_reset();
        chk(err == 1'b0, "R1", {31'd0, err}, 32'd0);
        send_byte(8'h06);
        chk(err == 1'b1, "R8", {31'd0, err}, 32'd1);
        read_word(8'h00, w);
        chk(w == 16'hBABA, "R8", {16'd0, w}, 32'hBABA);
        chk(err == 1'b1, "R8", {31'd0, err}, 32'd1);
        // R3: reversed read opcode bits (0xC0) is not a read
        do_reset();
        send_byte(8'hC0);
        chk(err == 1'b1, "R3", {31'd0, err}, 32'd1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule